// File: doc/BRIEF.md
# Gated Trace Message Clock Divider

This block derives the clock that paces a trace port's outgoing messages from the system clock. The output runs at the system rate divided by 1, 2, 4 or 8, chosen by a two-bit select input. A one-cycle tick marks the start of every divided period. Downstream logic that runs on the system clock can use the tick as a clock enable instead of crossing into a second clock domain.

Two controls stop the output. A plain enable turns the divided clock off. A gate mode stops it whenever the trace port reports that it has nothing to send. In both cases the stop and the restart happen only at a period boundary, where the divided clock is low, so no runt pulse ever leaves the block. A new divide select is adopted in the same way, only when a period ends.

A status output flags one unsupported configuration: divide-by-1 selected while the traced consumer runs at half the system rate.

Top module: `trace_clk_div`

## Requirements
- R1: The select encodes the ratio as 00 = ÷1, 01 = ÷2, 10 = ÷4 and 11 = ÷8. A period of ratio N lasts N system cycles. In ÷1, `msg_clk` is held high and `msg_tick` is high in every running cycle.
- R2: While reset is applied, and for two system cycles after it is released, `msg_clk`, `msg_tick` and `cfg_bad` are low. The latched ratio after reset is ÷2, so the first period after reset is ÷2 whatever the select input says.
- R3: When `clk_on` is low, the current period runs to its end. From then on `msg_clk` stays low until the block is allowed to run again.
- R4: When `idle_gate` is high and `trace_busy` is low, the output stops exactly as in R3. When `idle_gate` is low, `trace_busy` has no effect.
- R5: A new value on `div_sel` is adopted only in the last cycle of a running period and applies from the next period. While the output is stopped, the latched ratio does not change.
- R6: For ÷2, ÷4 and ÷8, `msg_clk` is high for the first N/2 cycles of each period and low for the remaining N/2 cycles, giving a 50% duty cycle.
- R7: `cfg_bad` is high in the cycle after a cycle in which `div_sel` is 00 and `half_rate_trace` is high, and low otherwise.
- R8: `msg_tick` is high exactly in the first cycle of each running period, which is the cycle in which `msg_clk` rises in ÷2, ÷4 and ÷8. It stays low while the output is stopped.
- R9: When the output is stopped and running becomes allowed, a full period begins in the next cycle, using the latched ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| div_sel | input | 2 | Divide select (00 ÷1, 01 ÷2, 10 ÷4, 11 ÷8) |
| clk_on | input | 1 | Output enable; low stops the divided clock |
| idle_gate | input | 1 | Gate mode; when high, the output stops whenever the port is idle |
| trace_busy | input | 1 | High while the trace port is sending messages |
| half_rate_trace | input | 1 | High when the traced consumer runs at half the system rate |
| msg_clk | output | 1 | Divided message clock, registered |
| msg_tick | output | 1 | One-cycle pulse at the start of each divided period |
| cfg_bad | output | 1 | Flags ÷1 selected while `half_rate_trace` is high |

## Verification
The divider is run at each of the four ratios for several full periods. This separates a wrong encoding, a wrong duty split and a misplaced tick. The select is changed mid-period, and the first period after reset is run with ÷8 already selected; these cases show whether the ratio is adopted early or only at the wrap. The enable and the idle gate are dropped in the middle of high and low phases, with `trace_busy` toggled both with and without gate mode. This distinguishes a clean stop at the period end from a truncated pulse, and shows whether the busy input is wrongly honoured when gating is off. The half-rate flag is driven with every select value.

// File: rtl/mcd_pkg.sv
`timescale 1ns/1ps
package mcd_pkg;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned CNT_W = (1 << SEL_W) - 1;

  typedef enum logic [SEL_W-1:0] {
    DIV_1 = 2'b00,
    DIV_2 = 2'b01,
    DIV_4 = 2'b10,
    DIV_8 = 2'b11
  } div_code_e;
endpackage

// File: rtl/mcd_rst_sync.sv
`timescale 1ns/1ps
module mcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/mcd_run_qual.sv
`timescale 1ns/1ps
module mcd_run_qual (
  input  logic clk_on,
  input  logic idle_gate,
  input  logic trace_busy,
  output logic run
);
  logic gate_ok;

  always_comb begin
    gate_ok = !idle_gate || trace_busy;
    run     = clk_on && gate_ok;
  end
endmodule

// File: rtl/mcd_period_ctr.sv
`timescale 1ns/1ps
module mcd_period_ctr #(
  parameter int unsigned          SEL_W     = 2,
  parameter int unsigned          CNT_W     = 3,
  parameter logic [SEL_W-1:0]     RESET_SEL = 2'b01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel_in,
  output logic             act_nx,
  output logic [SEL_W-1:0] sel_nx,
  output logic [CNT_W-1:0] cnt_nx
);
  logic             act_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;
  logic             last;
  logic             ce;

  // next state
  always_comb begin
    span   = (CNT_W+1)'(1) << sel_q;
    last   = (cnt_q == CNT_W'(span - 1'b1));
    act_nx = act_q;
    sel_nx = sel_q;
    cnt_nx = cnt_q + 1'b1;
    if (!act_q) begin
      act_nx = run;
      cnt_nx = '0;
    end else if (last) begin
      act_nx = run;
      sel_nx = sel_in;
      cnt_nx = '0;
    end
    ce = act_q || run;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sel_q <= RESET_SEL;
      cnt_q <= '0;
    end else if (ce) begin
      act_q <= act_nx;
      sel_q <= sel_nx;
      cnt_q <= cnt_nx;
    end
  end
endmodule

// File: rtl/mcd_wave_out.sv
`timescale 1ns/1ps
module mcd_wave_out #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_nx,
  input  logic [SEL_W-1:0] sel_nx,
  input  logic [CNT_W-1:0] cnt_nx,
  output logic             wave,
  output logic             tick
);
  logic [CNT_W:0] half;
  logic           wave_d;
  logic           tick_d;

  always_comb begin
    half   = ((CNT_W+1)'(1) << sel_nx) >> 1;
    wave_d = act_nx && ((sel_nx == '0) || ({1'b0, cnt_nx} < half));
    tick_d = act_nx && (cnt_nx == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave <= 1'b0;
      tick <= 1'b0;
    end else begin
      wave <= wave_d;
      tick <= tick_d;
    end
  end
endmodule

// File: rtl/mcd_cfg_check.sv
`timescale 1ns/1ps
module mcd_cfg_check #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             half_rate,
  output logic             bad
);
  logic bad_d;

  always_comb bad_d = (sel_in == SEL_W'(mcd_pkg::DIV_1)) && half_rate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad <= 1'b0;
    else        bad <= bad_d;
  end
endmodule

// File: rtl/trace_clk_div.sv
`timescale 1ns/1ps
module trace_clk_div #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_sys,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  input  logic       clk_on,
  input  logic       idle_gate,
  input  logic       trace_busy,
  input  logic       half_rate_trace,
  output logic       msg_clk,
  output logic       msg_tick,
  output logic       cfg_bad
);
  localparam int unsigned SEL_W = mcd_pkg::SEL_W;
  localparam int unsigned CNT_W = mcd_pkg::CNT_W;

  logic             rst_q_n;
  logic             run;
  logic             act_nx;
  logic [SEL_W-1:0] sel_nx;
  logic [CNT_W-1:0] cnt_nx;

  mcd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk_sys), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  mcd_run_qual u_run (
    .clk_on(clk_on), .idle_gate(idle_gate), .trace_busy(trace_busy), .run(run)
  );

  mcd_period_ctr #(
    .SEL_W(SEL_W), .CNT_W(CNT_W), .RESET_SEL(SEL_W'(mcd_pkg::DIV_2))
  ) u_ctr (
    .clk(clk_sys), .rst_n(rst_q_n), .run(run), .sel_in(div_sel),
    .act_nx(act_nx), .sel_nx(sel_nx), .cnt_nx(cnt_nx)
  );

  mcd_wave_out #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_wave (
    .clk(clk_sys), .rst_n(rst_q_n), .act_nx(act_nx), .sel_nx(sel_nx),
    .cnt_nx(cnt_nx), .wave(msg_clk), .tick(msg_tick)
  );

  mcd_cfg_check #(.SEL_W(SEL_W)) u_cfg (
    .clk(clk_sys), .rst_n(rst_q_n), .sel_in(div_sel),
    .half_rate(half_rate_trace), .bad(cfg_bad)
  );
endmodule

// File: rtl/mcd_sva.sv
`timescale 1ns/1ps
module mcd_sva (
  input logic clk_sys,
  input logic rst_n,
  input logic clk_on,
  input logic idle_gate,
  input logic trace_busy,
  input logic half_rate_trace,
  input logic msg_clk,
  input logic msg_tick,
  input logic cfg_bad
);
  assert_enable_hold_R3: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (!clk_on && !msg_clk) |=> !msg_clk);

  assert_gate_hold_R4: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (idle_gate && !trace_busy && !msg_clk) |=> !msg_clk);

  assert_flag_clear_R7: assert property (@(posedge clk_sys) disable iff (!rst_n)
    !half_rate_trace |=> !cfg_bad);

  assert_rise_tick_R8: assert property (@(posedge clk_sys) disable iff (!rst_n)
    $rose(msg_clk) |-> msg_tick);

  assert_tick_high_R8: assert property (@(posedge clk_sys) disable iff (!rst_n)
    msg_tick |-> msg_clk);

  assert_stop_quiet_R3: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (!clk_on && !msg_clk) |=> !msg_tick);
endmodule

bind trace_clk_div mcd_sva u_sva (
  .clk_sys(clk_sys), .rst_n(rst_n), .clk_on(clk_on), .idle_gate(idle_gate),
  .trace_busy(trace_busy), .half_rate_trace(half_rate_trace),
  .msg_clk(msg_clk), .msg_tick(msg_tick), .cfg_bad(cfg_bad)
);

// File: tb/tb_trace_clk_div.sv
`timescale 1ns/1ps
module tb_trace_clk_div;
  logic       clk_sys = 1'b0;
  logic       rst_n;
  logic [1:0] div_sel;
  logic       clk_on, idle_gate, trace_busy, half_rate_trace;
  logic       msg_clk, msg_tick, cfg_bad;

  int n_vec  = 0;
  int n_fail = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  // reference state, built from the requirements
  logic       m_act;
  logic [1:0] m_sel;
  int         m_cnt;
  logic       m_bad;

  always #2.5 clk_sys = ~clk_sys;

  trace_clk_div dut (
    .clk_sys(clk_sys), .rst_n(rst_n), .div_sel(div_sel), .clk_on(clk_on),
    .idle_gate(idle_gate), .trace_busy(trace_busy),
    .half_rate_trace(half_rate_trace), .msg_clk(msg_clk),
    .msg_tick(msg_tick), .cfg_bad(cfg_bad)
  );

  task automatic compare(input string tag, input logic [2:0] exp);
    n_vec++;
    if ({msg_clk, msg_tick, cfg_bad} !== exp) begin
      n_fail++;
      $display("FAIL %s: clk/tick/bad got %b expected %b at %0t",
               tag, {msg_clk, msg_tick, cfg_bad}, exp, $time);
    end
  endtask

  // driver: applies one cycle of inputs and predicts the outputs
  task automatic step(input string tag, input logic [1:0] sel, input logic en,
                      input logic gate, input logic busy, input logic half);
    logic run;
    logic ec, et;
    @(negedge clk_sys);
    div_sel = sel; clk_on = en; idle_gate = gate; trace_busy = busy;
    half_rate_trace = half;
    run = en && (!gate || busy);
    m_bad = (sel == 2'b00) && half;
    if (!m_act) begin
      m_act = run; m_cnt = 0;
    end else if (m_cnt == (1 << m_sel) - 1) begin
      m_act = run; m_sel = sel; m_cnt = 0;
    end else begin
      m_cnt++;
    end
    ec = m_act && ((m_sel == 2'b00) || (m_cnt < ((1 << m_sel) >> 1)));
    et = m_act && (m_cnt == 0);
    exp_q.push_back({ec, et, m_bad});
    tag_q.push_back(tag);
  endtask

  task automatic steps(input int n, input string tag, input logic [1:0] sel,
                       input logic en, input logic gate, input logic busy,
                       input logic half);
    for (int i = 0; i < n; i++) step(tag, sel, en, gate, busy, half);
  endtask

  // monitor: pops predictions as results appear
  initial begin
    forever begin
      @(posedge clk_sys);
      #1;
      if (exp_q.size() > 0) compare(tag_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk_sys);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; div_sel = 2'b11; clk_on = 1'b1; idle_gate = 1'b0;
    trace_busy = 1'b0; half_rate_trace = 1'b1;
    m_act = 1'b0; m_sel = 2'b01; m_cnt = 0; m_bad = 1'b0;
    repeat (3) @(posedge clk_sys);
    #1 compare("R2 in reset", 3'b000);
    @(negedge clk_sys) rst_n = 1'b1;
    half_rate_trace = 1'b0;
    @(posedge clk_sys); #1 compare("R2 release cycle 1", 3'b000);
    @(posedge clk_sys); #1 compare("R2 release cycle 2", 3'b000);

    // first period uses the reset ratio, then the ÷8 select is adopted
    steps(2,  "R2 first period div2", 2'b11, 1, 0, 0, 0);
    steps(24, "R5 div8 adopted at wrap", 2'b11, 1, 0, 0, 0);
    // each ratio
    steps(20, "R1 div1", 2'b00, 1, 0, 0, 0);
    steps(20, "R6 div4 duty", 2'b10, 1, 0, 0, 0);
    steps(12, "R6 div2 duty", 2'b01, 1, 0, 0, 0);
    steps(19, "R6 div8 duty", 2'b11, 1, 0, 0, 0);
    // change mid-period
    steps(3,  "R5 mid-period change", 2'b10, 1, 0, 0, 0);
    steps(5,  "R5 mid-period change", 2'b01, 1, 0, 0, 0);
    steps(12, "R5 settle", 2'b10, 1, 0, 0, 0);
    // enable off in the high phase of a ÷8 period
    steps(18, "R1 div8 run", 2'b11, 1, 0, 0, 0);
    steps(14, "R3 enable off", 2'b11, 0, 0, 0, 0);
    steps(6,  "R5 stopped keeps ratio", 2'b00, 0, 0, 0, 0);
    steps(20, "R9 restart", 2'b01, 1, 0, 0, 0);
    // idle gating
    steps(10, "R4 gate busy", 2'b10, 1, 1, 1, 0);
    steps(3,  "R4 gate idle", 2'b10, 1, 1, 0, 0);
    steps(12, "R4 gate idle hold", 2'b10, 1, 1, 0, 0);
    steps(1,  "R9 busy restart", 2'b10, 1, 1, 1, 0);
    steps(2,  "R4 busy drops early", 2'b10, 1, 1, 0, 0);
    steps(8,  "R4 busy drops early", 2'b10, 1, 1, 0, 0);
    for (int i = 0; i < 24; i++)
      step("R4 busy ignored without gate", 2'b10, 1, 0, logic'(i % 3 == 0), 0);
    for (int i = 0; i < 30; i++)
      step("R8 gate toggling", 2'b01, 1, 1, logic'((i / 5) % 2), 0);
    steps(8,  "R8 div1 gated", 2'b00, 1, 1, 0, 0);
    steps(6,  "R8 div1 running", 2'b00, 1, 1, 1, 0);
    // half-rate flag
    for (int s = 0; s < 4; s++) begin
      steps(3, "R7 flag", 2'(s), 1, 0, 0, 1);
      steps(2, "R7 flag clear", 2'(s), 1, 0, 0, 0);
    end
    steps(4, "R7 flag div1", 2'b00, 1, 0, 0, 1);

    @(posedge clk_sys); #2;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule